// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels may use the bus next. It holds a 16-bit control register. The register carries a two-bit arbitration mode, a master enable and two sticky status flags. When the arbiter is idle and enabled, it issues a one-hot grant to the requesting channel that ranks highest in the current priority order. It then holds that grant until the transfer-complete input is seen.

Two modes use a fixed ranking and two use a rotating ranking. In the rotating modes, the channel that has just finished drops to the bottom of the order, and the other channels keep their cyclic order. Writing a different mode value loads the starting order of that mode. The status flags are set by hardware pulses from outside the block. Software can only clear them, by writing 0.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset the register reads 0x0000, `gnt` is 0, and the mode is fixed order 0>3>2>1.
- R2: Register bits 15:10 and 7:3 always read 0, whatever value was written.
- R3: With mode field bits 9:8 = 00, the grant goes to the requester that ranks first in the fixed order channel 0, then 3, then 2, then 1.
- R4: With mode 01, the grant follows the fixed order channel 1, then 3, then 2, then 0.
- R5: Mode 10 is rotating and starts from order 0,3,2,1. On each completed transfer, the finished channel moves to the lowest rank and the other channels keep their relative order.
- R6: Mode 11 is rotating in the same way and starts from order 3,2,1,0.
- R7: A register write that changes the mode field reloads the priority order with the new mode's starting order. If a completion happens in the same cycle, the reload takes precedence over the rotation.
- R8: Flags at bit 2 (address error) and bit 1 (interrupt flag) are cleared only by writing 0 to them. Writing 1 leaves them unchanged and never sets them.
- R9: A set pulse on a flag in the same cycle as a software clear leaves the flag at 1.
- R10: While the enable bit 0 reads 0, no new grant is issued.
- R11: `gnt` is one-hot or zero. A new grant appears one cycle after an idle, enabled cycle with requests, and it selects a channel that was requesting. The grant is held until a cycle with `xfer_done` high and then drops to 0. `xfer_done` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register contents |
| req | input | 4 | Per-channel transfer requests |
| xfer_done | input | 1 | Completion of the granted transfer |
| aerr_set | input | 1 | Set pulse for the address error flag (bit 2) |
| nmi_set | input | 1 | Set pulse for the interrupt flag (bit 1) |
| gnt | output | 4 | One-hot grant |

## Verification
The hardest state to reach is a rotating order several completions away from its starting point, followed by a mode rewrite that has to restore that starting point. It is harder still when the rewrite lands in the same cycle as a completion. The random phase keeps all four requests busy, raises `xfer_done` often and rewrites the mode only rarely, so long rotation histories build up before a reload. A reference model in the bench tracks the expected order throughout. Directed steps force a clear and a set pulse into the same cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   localparam int MODE_W   = 2;
   localparam int MODE_LSB = 8;
   localparam int AERR_BIT = 2;
   localparam int NMI_BIT  = 1;
   localparam int EN_BIT   = 0;
   localparam int NUM_FLAG = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_FIX_A  = 2'b00,
      MODE_FIX_B  = 2'b01,
      MODE_ROT    = 2'b10,
      MODE_ROT_EX = 2'b11
   } arb_mode_e;
endpackage

// File: rtl/dma_arb_ctrl_reg.sv
module dma_arb_ctrl_reg
   import dma_arb_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              aerr_set,
   input  logic              nmi_set,
   output logic [DATA_W-1:0] rdata,
   output arb_mode_e         mode,
   output logic              enable,
   output logic              mode_chg,
   output arb_mode_e         new_mode
);
   localparam int FLAG_POS [NUM_FLAG] = '{AERR_BIT, NMI_BIT};

   logic [NUM_FLAG-1:0] flag_q;
   logic [NUM_FLAG-1:0] flag_set;
   logic                unused_wbits;

   assign flag_set     = {nmi_set, aerr_set};
   assign new_mode     = arb_mode_e'(wdata[MODE_LSB +: MODE_W]);
   assign mode_chg     = wr_en && (new_mode != mode);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode   <= MODE_FIX_A;
         enable <= 1'b0;
      end else if (wr_en) begin
         mode   <= new_mode;
         enable <= wdata[EN_BIT];
      end
   end

   generate
      for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
         logic sw_clr;
         assign sw_clr = wr_en && !wdata[FLAG_POS[f]];
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag_q[f] <= 1'b0;
            else
               flag_q[f] <= flag_set[f] | (flag_q[f] & ~sw_clr);
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      rdata[MODE_LSB +: MODE_W] = mode;
      rdata[AERR_BIT]           = flag_q[0];
      rdata[NMI_BIT]            = flag_q[1];
      rdata[EN_BIT]             = enable;
   end
endmodule

// File: rtl/dma_arb_order.sv
module dma_arb_order
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reload,
   input  arb_mode_e                    reload_mode,
   input  logic                         rotate,
   input  logic [CH_W-1:0]              done_ch,
   output logic [NUM_CH-1:0][CH_W-1:0]  order_q
);
   typedef logic [NUM_CH-1:0][CH_W-1:0] ord_t;

   function automatic ord_t start_order(arb_mode_e m);
      ord_t o;
      for (int i = 0; i < NUM_CH; i++) begin
         case (m)
            MODE_FIX_B:  o[i] = (i == 0) ? CH_W'(1) :
                                (i == NUM_CH-1) ? CH_W'(0) : CH_W'(NUM_CH - i);
            MODE_ROT_EX: o[i] = CH_W'(NUM_CH - 1 - i);
            default:     o[i] = (i == 0) ? CH_W'(0) : CH_W'(NUM_CH - i);
         endcase
      end
      return o;
   endfunction

   logic [CH_W-1:0] done_pos;
   ord_t            rot_d;

   always_comb begin
      done_pos = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (order_q[i] == done_ch) done_pos = CH_W'(i);
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_rot
         if (g == NUM_CH - 1) begin : g_tail
            assign rot_d[g] = done_ch;
         end else begin : g_body
            assign rot_d[g] = (CH_W'(g) < done_pos) ? order_q[g] : order_q[g+1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         order_q <= start_order(MODE_FIX_A);
      else if (reload)
         order_q <= start_order(reload_mode);
      else if (rotate)
         order_q <= rot_d;
   end
endmodule

// File: rtl/dma_arb_grant.sv
module dma_arb_grant #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enable,
   input  logic [NUM_CH-1:0]           req,
   input  logic                        done,
   input  logic [NUM_CH-1:0][CH_W-1:0] order,
   output logic [NUM_CH-1:0]           gnt,
   output logic                        finish,
   output logic [CH_W-1:0]             gnt_ch
);
   logic            found;
   logic [CH_W-1:0] sel;

   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (!found && req[order[i]]) begin
            found = 1'b1;
            sel   = order[i];
         end
      end
   end

   always_comb begin
      gnt_ch = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (gnt[i]) gnt_ch = CH_W'(i);
   end

   assign finish = (gnt != '0) && done;

   always_ff @(posedge clk) begin
      if (!rst_n)
         gnt <= '0;
      else if (gnt != '0) begin
         if (done) gnt <= '0;
      end else if (enable && found)
         gnt <= NUM_CH'(1) << sel;
   end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] req,
   input  logic              xfer_done,
   input  logic              aerr_set,
   input  logic              nmi_set,
   output logic [NUM_CH-1:0] gnt
);
   localparam int CH_W = $clog2(NUM_CH);

   generate
      if (NUM_CH != 4) begin : g_bad_ch
         $error("dma_prio_arb: priority orders are defined for four channels");
      end
      if (DATA_W < MODE_LSB + MODE_W) begin : g_bad_w
         $error("dma_prio_arb: DATA_W too small for mode field");
      end
   endgenerate

   arb_mode_e                   mode, new_mode;
   logic                        enable, mode_chg, finish;
   logic [CH_W-1:0]             gnt_ch;
   logic [NUM_CH-1:0][CH_W-1:0] order;

   dma_arb_ctrl_reg #(.DATA_W(DATA_W)) reg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wdata    (reg_wdata),
      .aerr_set (aerr_set),
      .nmi_set  (nmi_set),
      .rdata    (reg_rdata),
      .mode     (mode),
      .enable   (enable),
      .mode_chg (mode_chg),
      .new_mode (new_mode)
   );

   dma_arb_order #(.NUM_CH(NUM_CH), .CH_W(CH_W)) order_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reload      (mode_chg),
      .reload_mode (new_mode),
      .rotate      (finish && mode[1]),
      .done_ch     (gnt_ch),
      .order_q     (order)
   );

   dma_arb_grant #(.NUM_CH(NUM_CH), .CH_W(CH_W)) grant_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .req    (req),
      .done   (xfer_done),
      .order  (order),
      .gnt    (gnt),
      .finish (finish),
      .gnt_ch (gnt_ch)
   );
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NUM_CH-1:0] req,
   input logic              xfer_done,
   input logic              aerr_set,
   input logic              nmi_set,
   input logic [NUM_CH-1:0] gnt
);
   // R11
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R11
   gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && !xfer_done) |=> gnt == $past(gnt));

   // R11
   gnt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && xfer_done) |=> gnt == '0);

   // R11
   gnt_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && reg_rdata[0] && req != '0) |=> (gnt & $past(req)) != '0);

   // R10
   no_gnt_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && !reg_rdata[0]) |=> gnt == '0);

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:10] == '0 && reg_rdata[7:3] == '0);

   // R9
   aerr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aerr_set |=> reg_rdata[2]);

   // R9
   nmi_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_set |=> reg_rdata[1]);

   // R8
   aerr_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!aerr_set && !reg_rdata[2]) |=> !reg_rdata[2]);

   // R8
   nmi_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nmi_set && !reg_rdata[1]) |=> !reg_rdata[1]);
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_rdata (reg_rdata),
   .req       (req),
   .xfer_done (xfer_done),
   .aerr_set  (aerr_set),
   .nmi_set   (nmi_set),
   .gnt       (gnt)
);

// File: tb/dma_prio_arb_tb_top.sv
`timescale 1ns/1ps
module dma_prio_arb_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [3:0]  req = '0;
   logic        xfer_done = 1'b0;
   logic        aerr_set = 1'b0;
   logic        nmi_set = 1'b0;
   logic [3:0]  gnt;

   int n_chk = 0;
   int n_fail = 0;

   int          m_mode, m_en, m_aerr, m_nmi;
   int          m_ord [4];
   logic [3:0]  m_gnt;

   always #4 clk = ~clk;

   dma_prio_arb dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .req(req), .xfer_done(xfer_done),
      .aerr_set(aerr_set), .nmi_set(nmi_set), .gnt(gnt)
   );

   function automatic int start_ch(int mode, int pos);
      case (mode)
         1:       return (pos == 0) ? 1 : (pos == 3) ? 0 : 4 - pos;
         3:       return 3 - pos;
         default: return (pos == 0) ? 0 : 4 - pos;
      endcase
   endfunction

   function automatic logic [15:0] exp_reg();
      logic [15:0] r = '0;
      r[9:8] = 2'(m_mode);
      r[2]   = m_aerr[0];
      r[1]   = m_nmi[0];
      r[0]   = m_en[0];
      return r;
   endfunction

   function automatic string mode_tag(int mode);
      case (mode)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_mode = 0; m_en = 0; m_aerr = 0; m_nmi = 0; m_gnt = '0;
      for (int i = 0; i < 4; i++) m_ord[i] = start_ch(0, i);
   endtask

   // Called at a negative edge; applies inputs, advances model, checks at next negedge.
   task automatic step(string tag, bit wr, logic [15:0] wd, logic [3:0] rq,
                       bit dn, bit as, bit ns);
      logic [3:0] ng;
      bit         rot, reload;
      int         gch, pos;
      int         nord [4];
      string      gtag;
      reg_wr_en = wr; reg_wdata = wd; req = rq; xfer_done = dn;
      aerr_set = as; nmi_set = ns;
      gtag = (tag != "") ? tag : ((m_en == 0) ? "R10" : mode_tag(m_mode));
      ng = m_gnt; rot = 0; gch = 0;
      if (m_gnt != '0) begin
         for (int i = 0; i < 4; i++) if (m_gnt[i]) gch = i;
         if (dn) begin ng = '0; rot = (m_mode >= 2); end
      end else if (m_en != 0) begin
         for (int i = 3; i >= 0; i--) if (rq[m_ord[i]]) ng = 4'(1 << m_ord[i]);
      end
      m_aerr = (as || (m_aerr != 0 && !(wr && !wd[2]))) ? 1 : 0;
      m_nmi  = (ns || (m_nmi  != 0 && !(wr && !wd[1]))) ? 1 : 0;
      reload = wr && (int'(wd[9:8]) != m_mode);
      if (reload) begin
         for (int i = 0; i < 4; i++) m_ord[i] = start_ch(int'(wd[9:8]), i);
      end else if (rot) begin
         pos = 0;
         for (int i = 0; i < 4; i++) if (m_ord[i] == gch) pos = i;
         for (int i = 0; i < 4; i++)
            nord[i] = (i == 3) ? gch : (i < pos) ? m_ord[i] : m_ord[i+1];
         for (int i = 0; i < 4; i++) m_ord[i] = nord[i];
      end
      if (wr) begin m_mode = int'(wd[9:8]); m_en = int'(wd[0]); end
      m_gnt = ng;
      @(posedge clk);
      @(negedge clk);
      check(gtag, {12'b0, gnt}, {12'b0, m_gnt});
      check((tag != "") ? tag : "R8", reg_rdata, exp_reg());
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step("", 0, 16'h0, 4'h0, 0, 0, 0);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", reg_rdata, 16'h0000);
      check("R1", {12'b0, gnt}, 16'h0);
      // R10 disabled: requests produce no grant
      step("R10", 0, 16'h0, 4'hF, 0, 0, 0);
      // R2, R8: write all ones; reserved and flags stay 0
      step("R2", 1, 16'hFFFF, 4'h0, 0, 0, 0);
      // R3 fixed order 0>3>2>1
      step("R3", 1, 16'h0001, 4'h0, 0, 0, 0);
      step("R3", 0, 16'h0, 4'b0110, 0, 0, 0);   // ch2
      step("R11", 0, 16'h0, 4'b0001, 0, 0, 0);  // held
      step("R11", 0, 16'h0, 4'b0001, 1, 0, 0);  // release
      step("R3", 0, 16'h0, 4'b1011, 0, 0, 0);   // ch0
      step("R11", 0, 16'h0, 4'h0, 1, 0, 0);
      step("R11", 0, 16'h0, 4'h0, 1, 0, 0);     // done while idle
      // R4 fixed order 1>3>2>0
      step("R4", 1, 16'h0101, 4'h0, 0, 0, 0);
      step("R4", 0, 16'h0, 4'b1001, 0, 0, 0);   // ch3
      step("R4", 0, 16'h0, 4'h0, 1, 0, 0);
      step("R4", 0, 16'h0, 4'b1111, 0, 0, 0);   // ch1
      step("R4", 0, 16'h0, 4'h0, 1, 0, 0);
      // R5 rotating from 0,3,2,1
      step("R5", 1, 16'h0201, 4'h0, 0, 0, 0);
      for (int k = 0; k < 6; k++) begin
         step("R5", 0, 16'h0, 4'hF, 0, 0, 0);
         step("R5", 0, 16'h0, 4'hF, 1, 0, 0);
      end
      // R6 and R7: mode change reloads order
      step("R7", 1, 16'h0301, 4'h0, 0, 0, 0);
      step("R6", 0, 16'h0, 4'hF, 0, 0, 0);      // ch3
      step("R6", 0, 16'h0, 4'hF, 1, 0, 0);
      step("R6", 0, 16'h0, 4'hF, 0, 0, 0);      // ch2
      step("R7", 1, 16'h0201, 4'hF, 1, 0, 0);   // reload beats rotation
      step("R7", 0, 16'h0, 4'hF, 0, 0, 0);      // ch0
      step("R7", 0, 16'h0, 4'h0, 1, 0, 0);
      // R9 set wins over clear; R8 write 1 keeps, write 0 clears
      step("R9", 1, 16'h0201, 4'h0, 0, 1, 1);
      step("R8", 1, 16'h0207, 4'h0, 0, 0, 0);
      step("R8", 1, 16'h0203, 4'h0, 0, 0, 0);
      step("R8", 1, 16'h0201, 4'h0, 0, 0, 0);
      // R10 grant held while disabled, no regrant afterwards
      step("R10", 0, 16'h0, 4'hF, 0, 0, 0);
      step("R10", 1, 16'h0200, 4'hF, 0, 0, 0);
      step("R10", 0, 16'h0, 4'hF, 1, 0, 0);
      step("R10", 0, 16'h0, 4'hF, 0, 0, 0);
      idle(2);
      // random phase
      for (int k = 0; k < 5000; k++) begin
         bit         wr;
         logic [15:0] wd;
         wr = ($urandom_range(0, 39) == 0);
         wd = 16'($urandom);
         wd[0] = ($urandom_range(0, 7) != 0);
         step("", wr, wd, 4'($urandom), ($urandom_range(0, 2) == 0),
              ($urandom_range(0, 29) == 0), ($urandom_range(0, 29) == 0));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule